// File: doc/BRIEF.md
# One-Shot RAM Self-Test Sequencer

This block runs a march-style built-in self-test over a single-port synchronous RAM, once per power cycle, when software asks for it. A start request, taken when the block is idle, moves it out of its idle state. It then removes the CPU's grant to the RAM and issues one RAM operation per clock until the whole algorithm has run. At the end it raises a done flag together with a pass/fail flag. Both flags stay as they are until the next power-on reset. Any start request after the first one does nothing.

The algorithm has six march elements over the whole address space, using all-zeros and all-ones data backgrounds. Element 0 writes zeros in ascending address order. Elements 1 and 2 run in ascending order and read the expected value and then write its inverse at each address. Elements 3 and 4 do the same in descending order. Element 5 reads zeros in ascending order. Read data comes back one cycle after the read is issued and is compared with the expected background. Any mismatch latches the fail flag.

The sequencer moves through named states. IDLE goes to FILL when a start is taken. FILL goes to READ after the last address. READ goes to WRITE on every cycle. WRITE goes back to READ for the next address or the next element. WRITE goes to SCAN after the last address of element 4. SCAN goes to DRAIN after the last address. DRAIN goes to DONE after one cycle, during which the last read is compared. DONE is terminal.

Top module: `ram_bist_oneshot`

## Requirements
- R1: After power-on reset (rst_n low), busy_o, done_o and fail_o are 0, cpu_grant_o is 1 and ram_en_o is 0.
- R2: If start_i is 1 at a rising clock edge while the block is idle, busy_o is 1 from the next cycle on. cpu_grant_o is 0 for every cycle in which busy_o is 1.
- R3: The RAM operations follow this exact order, one per clock. Ascending means address 0 up to 2^AW-1 and descending means the reverse. E0 ascending: write 0. E1 ascending: read, then write all-ones. E2 ascending: read, then write 0. E3 descending: read, then write all-ones. E4 descending: read, then write 0. E5 ascending: read. ram_we_o is 1 for a write and 0 for a read.
- R4: busy_o stays 1 for exactly 10*2^AW+1 cycles. done_o rises in the cycle in which busy_o falls.
- R5: Each read is compared one cycle after it is issued, against all-zeros in E1, E3 and E5 and against all-ones in E2 and E4. Any mismatch makes fail_o 1 by the time done_o is 1.
- R6: Once fail_o is 1 it stays 1. Once done_o is 1 it stays 1. Both hold until power-on reset.
- R7: With a fault-free RAM, fail_o is 0 when done_o is 1.
- R8: start_i has no effect while busy_o or done_o is 1: no new RAM operation is issued, and done_o and fail_o do not change.
- R9: Only power-on reset re-arms the block. After it, a new start request runs the full test again.
- R10: ram_en_o is 0 whenever busy_o is 0, so no RAM operation occurs outside a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| start_i | input | 1 | Start request (control-register enable bit) |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test finished (sticky) |
| fail_o | output | 1 | RAM fault found; valid when done_o is 1 |
| cpu_grant_o | output | 1 | CPU may access the RAM |
| ram_en_o | output | 1 | RAM operation enable |
| ram_we_o | output | 1 | RAM write enable (0 = read) |
| ram_addr_o | output | AW | RAM address |
| ram_wdata_o | output | DW | RAM write data |
| ram_rdata_i | input | DW | RAM read data, one cycle after the read |

## Verification
The hardest case is a fault that shows up in only one march element, because only the read/compare path can detect it. The bench RAM model forces a single bit at a chosen address to a fixed level when it is read. A stuck-at-1 at a low address must be caught by the first zero-background read. A stuck-at-0 at the top address must be caught by the descending all-ones read, which reaches that address first. The second one-shot case is reached by holding start_i high through and after a whole run, and by pulsing it again after done. The operation scoreboard then shows that no operation is issued outside the expected sequence.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_READ,
        ST_WRITE,
        ST_SCAN,
        ST_DRAIN,
        ST_DONE
    } mbist_state_e;

    localparam int unsigned ELEM_W    = 3;
    localparam logic [ELEM_W-1:0] ELEM_LAST_RW = 3'd4;
    localparam logic [ELEM_W-1:0] ELEM_SCAN    = 3'd5;

    // Elements 3 and 4 walk the address space downward.
    function automatic logic elem_desc(input logic [ELEM_W-1:0] e);
        return (e == 3'd3) || (e == 3'd4);
    endfunction

    // Background bit expected by the read of an element.
    function automatic logic elem_rd_bit(input logic [ELEM_W-1:0] e);
        return (e == 3'd2) || (e == 3'd4);
    endfunction

    // Background bit written by an element.
    function automatic logic elem_wr_bit(input logic [ELEM_W-1:0] e);
        return (e == 3'd1) || (e == 3'd3);
    endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_hi,
    input  logic          step,
    input  logic          down,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] ADDR_MAX = {AW{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_hi ? ADDR_MAX : '0;
        end else if (step) begin
            addr <= down ? addr - 1'b1 : addr + 1'b1;
        end
    end

    assign last = down ? (addr == '0) : (addr == ADDR_MAX);

endmodule

// File: rtl/mbist_fsm.sv
module mbist_fsm
    import mbist_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic addr_last,
    output logic addr_load,
    output logic addr_load_hi,
    output logic addr_step,
    output logic addr_down,
    output logic ram_en,
    output logic ram_we,
    output logic wr_bit,
    output logic rd_issue,
    output logic exp_bit,
    output logic busy,
    output logic done
);
    mbist_state_e      state_q, state_d;
    logic [ELEM_W-1:0] elem_q, elem_d;
    logic [ELEM_W-1:0] elem_nxt;

    assign elem_nxt = elem_q + 3'd1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            elem_q  <= '0;
        end else begin
            state_q <= state_d;
            elem_q  <= elem_d;
        end
    end

    // Transitions
    always_comb begin
        state_d      = state_q;
        elem_d       = elem_q;
        addr_load    = 1'b0;
        addr_load_hi = 1'b0;
        addr_step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d   = ST_FILL;
                    elem_d    = '0;
                    addr_load = 1'b1;
                end
            end
            ST_FILL: begin
                if (addr_last) begin
                    state_d   = ST_READ;
                    elem_d    = 3'd1;
                    addr_load = 1'b1;
                end else begin
                    addr_step = 1'b1;
                end
            end
            ST_READ: begin
                state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (addr_last) begin
                    addr_load = 1'b1;
                    if (elem_q == ELEM_LAST_RW) begin
                        state_d = ST_SCAN;
                        elem_d  = ELEM_SCAN;
                    end else begin
                        state_d      = ST_READ;
                        elem_d       = elem_nxt;
                        addr_load_hi = elem_desc(elem_nxt);
                    end
                end else begin
                    state_d   = ST_READ;
                    addr_step = 1'b1;
                end
            end
            ST_SCAN: begin
                if (addr_last) state_d = ST_DRAIN;
                else           addr_step = 1'b1;
            end
            ST_DRAIN: begin
                state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        addr_down = elem_desc(elem_q);
        wr_bit    = elem_wr_bit(elem_q);
        exp_bit   = elem_rd_bit(elem_q);
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        rd_issue  = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_FILL:  begin ram_en = 1'b1; ram_we = 1'b1; end
            ST_READ:  begin ram_en = 1'b1; rd_issue = 1'b1; end
            ST_WRITE: begin ram_en = 1'b1; ram_we = 1'b1; end
            ST_SCAN:  begin ram_en = 1'b1; rd_issue = 1'b1; end
            ST_DRAIN: ;
            ST_DONE:  begin busy = 1'b0; done = 1'b1; end
            default:  busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_issue,
    input  logic          exp_bit,
    input  logic [DW-1:0] rdata,
    output logic          fail
);
    logic pend_q;
    logic pend_exp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_exp_q <= 1'b0;
            fail       <= 1'b0;
        end else begin
            pend_q     <= rd_issue;
            pend_exp_q <= exp_bit;
            if (pend_q && (rdata != {DW{pend_exp_q}})) fail <= 1'b1;
        end
    end

endmodule

// File: rtl/ram_bist_oneshot.sv
module ram_bist_oneshot #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          fail_o,
    output logic          cpu_grant_o,
    output logic          ram_en_o,
    output logic          ram_we_o,
    output logic [AW-1:0] ram_addr_o,
    output logic [DW-1:0] ram_wdata_o,
    input  logic [DW-1:0] ram_rdata_i
);
    logic addr_load, addr_load_hi, addr_step, addr_down, addr_last;
    logic wr_bit, rd_issue, exp_bit;

    mbist_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .addr_last    (addr_last),
        .addr_load    (addr_load),
        .addr_load_hi (addr_load_hi),
        .addr_step    (addr_step),
        .addr_down    (addr_down),
        .ram_en       (ram_en_o),
        .ram_we       (ram_we_o),
        .wr_bit       (wr_bit),
        .rd_issue     (rd_issue),
        .exp_bit      (exp_bit),
        .busy         (busy_o),
        .done         (done_o)
    );

    mbist_addr_gen #(.AW(AW)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (addr_load),
        .load_hi (addr_load_hi),
        .step    (addr_step),
        .down    (addr_down),
        .addr    (ram_addr_o),
        .last    (addr_last)
    );

    mbist_cmp #(.DW(DW)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_issue (rd_issue),
        .exp_bit  (exp_bit),
        .rdata    (ram_rdata_i),
        .fail     (fail_o)
    );

    assign ram_wdata_o = {DW{wr_bit}};
    assign cpu_grant_o = ~busy_o;

endmodule

// File: rtl/mbist_chk.sv
module mbist_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          fail_o,
    input logic          cpu_grant_o,
    input logic          ram_en_o,
    input logic          ram_we_o,
    input logic [DW-1:0] ram_wdata_o
);
    assert_start_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !done_o) |=> busy_o);

    assert_op_blocks_cpu_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en_o |-> (busy_o && !cpu_grant_o));

    assert_write_background_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en_o && ram_we_o) |-> ((ram_wdata_o == '0) || (ram_wdata_o == {DW{1'b1}})));

    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    assert_fail_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> fail_o);

    assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !ram_en_o));

    assert_fail_from_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> $past(ram_en_o && !ram_we_o, 2));

    assert_done_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $fell(busy_o));

endmodule

bind ram_bist_oneshot mbist_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .cpu_grant_o (cpu_grant_o),
    .ram_en_o    (ram_en_o),
    .ram_we_o    (ram_we_o),
    .ram_wdata_o (ram_wdata_o)
);

// File: tb/ram_bist_oneshot_test.sv
module ram_bist_oneshot_test;
    localparam int unsigned AW = 8;
    localparam int unsigned DW = 8;
    localparam int NWORDS = 1 << AW;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } op_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          busy_o, done_o, fail_o, cpu_grant_o;
    logic          ram_en_o, ram_we_o;
    logic [AW-1:0] ram_addr_o;
    logic [DW-1:0] ram_wdata_o;
    logic [DW-1:0] ram_rdata_i = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    op_t exp_q[$];

    // RAM model with a single forced bit
    logic [DW-1:0] mem [NWORDS];
    logic          flt_en = 1'b0;
    logic [AW-1:0] flt_addr = '0;
    int            flt_bit = 0;
    logic          flt_val = 1'b0;

    always_ff @(posedge clk) begin
        if (ram_en_o) begin
            if (ram_we_o) begin
                mem[ram_addr_o] <= ram_wdata_o;
            end else begin
                logic [DW-1:0] v;
                v = mem[ram_addr_o];
                if (flt_en && ram_addr_o == flt_addr) v[flt_bit] = flt_val;
                ram_rdata_i <= v;
            end
        end
    end

    ram_bist_oneshot #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
        .cpu_grant_o(cpu_grant_o), .ram_en_o(ram_en_o), .ram_we_o(ram_we_o),
        .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Driver side of the scoreboard: expected March C- operations (R3)
    task automatic push_op(input logic we, input int a, input logic [DW-1:0] d);
        op_t o;
        o.we = we; o.addr = AW'(a); o.data = d;
        exp_q.push_back(o);
    endtask

    task automatic push_march();
        for (int a = 0; a < NWORDS; a++) push_op(1'b1, a, '0);
        for (int e = 1; e <= 4; e++) begin
            for (int k = 0; k < NWORDS; k++) begin
                int a;
                a = (e >= 3) ? NWORDS - 1 - k : k;
                push_op(1'b0, a, '0);
                push_op(1'b1, a, (e == 1 || e == 3) ? {DW{1'b1}} : '0);
            end
        end
        for (int a = 0; a < NWORDS; a++) push_op(1'b0, a, '0);
    endtask

    // Monitor: every RAM operation must match the next expected item (R3, R8, R10)
    always @(negedge clk) begin
        if (rst_n && ram_en_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected RAM op", {ram_we_o, 23'd0, ram_addr_o}, 32'hffff_ffff);
            end else begin
                op_t o;
                o = exp_q.pop_front();
                check(ram_we_o == o.we && ram_addr_o == o.addr && (!o.we || ram_wdata_o == o.data),
                      "R3 op order", {7'd0, ram_we_o, ram_addr_o, 8'd0, ram_wdata_o},
                      {7'd0, o.we, o.addr, 8'd0, o.data});
            end
            check(!cpu_grant_o, "R10 grant during op", cpu_grant_o, 0);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            finish_sim();
        end
    end

    task automatic por();
        rst_n = 1'b0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !fail_o && cpu_grant_o && !ram_en_o, "R1 reset state",
              {busy_o, done_o, fail_o, cpu_grant_o, ram_en_o}, 5'b00010);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run(input bit hold_start, input bit exp_fail, input string tag);
        int busy_cnt;
        bit fail_seen;
        busy_cnt = 0;
        fail_seen = 0;
        push_march();
        start_i = 1'b1;
        @(negedge clk);
        if (!hold_start) start_i = 1'b0;
        check(busy_o && !cpu_grant_o, "R2 start taken", {busy_o, cpu_grant_o}, 2'b10);
        while (!done_o) begin
            if (busy_o) busy_cnt++;
            if (fail_seen) check(fail_o, "R6 fail sticky in run", fail_o, 1);
            if (fail_o) fail_seen = 1;
            check(cpu_grant_o == !busy_o, "R2 grant", cpu_grant_o, !busy_o);
            @(negedge clk);
        end
        check(busy_cnt == 10 * NWORDS + 1 && !busy_o, {"R4 run length ", tag}, busy_cnt, 10 * NWORDS + 1);
        check(exp_q.size() == 0, {"R3 all ops issued ", tag}, exp_q.size(), 0);
        if (exp_fail) check(fail_o == 1'b1, {"R5 fault detected ", tag}, fail_o, 1);
        else          check(fail_o == 1'b0, {"R7 clean pass ", tag}, fail_o, 0);
        // Second request must be ignored (R8)
        start_i = 1'b1;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        check(done_o && !busy_o && cpu_grant_o, "R8 second start ignored", {done_o, busy_o}, 2'b10);
        check(fail_o == exp_fail, "R6 fail held", fail_o, exp_fail);
    endtask

    initial begin
        // Idle: no start, no operation
        por();
        repeat (10) @(negedge clk);
        check(!busy_o && !ram_en_o && !done_o, "R10 idle quiet", {busy_o, ram_en_o}, 0);

        // Clean RAM, start held high through the whole run
        run(1'b1, 1'b0, "clean");

        // Stuck-at-1 on bit 0 at a low address
        por();
        check(!done_o, "R9 reset re-arms", done_o, 0);
        flt_en = 1'b1; flt_addr = AW'(5); flt_bit = 0; flt_val = 1'b1;
        run(1'b0, 1'b1, "sa1");

        // Stuck-at-0 on top bit at the last address
        por();
        flt_addr = {AW{1'b1}}; flt_bit = DW - 1; flt_val = 1'b0;
        run(1'b0, 1'b1, "sa0");

        // Clean again after a further reset (R9)
        por();
        flt_en = 1'b0;
        run(1'b0, 1'b0, "rerun");

        finish_sim();
    end

endmodule